// File: doc/BRIEF.md
# Configuration-Mode Register Access Sequencer

This block turns single register read and write requests into the byte traffic that an SPI-attached converter expects while it normally sits in conversion mode. The converter only listens to register traffic after an unlock command. So every accepted request becomes three chip-select frames:

1. A one-byte unlock frame.
2. The addressed transaction: a 16-bit big-endian address followed by 1 to 6 data bytes.
3. A three-byte frame that writes the leave-configuration bit.

Read data comes back on `rdata` together with a one-cycle `done` pulse. The bit-level SPI shifter sits outside this block. It is reached through a byte handshake: the sequencer presents `spi_tx` with `spi_req`, marks the final byte of a frame with `spi_last`, and the shifter answers each byte with a one-cycle `spi_ack` that also carries the received byte on `spi_rx`.

A write to address 0x0000 whose first data byte is 0x81 is a soft reset of the converter. The converter returns to conversion mode by itself after a soft reset. The sequencer therefore omits the leave frame and instead holds itself busy for a quiet window of `QUIET_US` microseconds, counted in cycles of a `CLK_HZ` clock. Requests that would break the frame limit, or that write to read-only identification registers, are refused at once with `done` and `err` and no SPI traffic.

The controller is one state machine with these states:

| State | Role | Leaves to |
|---|---|---|
| IDLE | waits for a request | REJECT on a bad request, ENTER otherwise |
| REJECT | pulses `done` and `err` | IDLE |
| ENTER | sends the unlock frame | XFER on its acknowledge |
| XFER | sends the address and data frame | EXIT on the final acknowledge, or FINISH for a reset write |
| EXIT | sends the leave frame | FINISH on its final acknowledge |
| FINISH | pulses `done` | QUIET after a reset write, IDLE otherwise |
| QUIET | counts out the lockout | IDLE when the count expires |

Top module: `cfg_access_seq`

## Requirements
- R1: Every accepted, valid request first produces a frame of exactly one byte, 0xA0, with `spi_last` high on that byte.
- R2: The second frame carries the address high byte, then the low byte, then `req_len` data bytes, with `spi_last` only on the final one. On a read, bit 7 of the high address byte is set and the data bytes are 0x00. On a write, data byte k is `req_wdata[8k+7:8k]`.
- R3: On a read, the byte returned on `spi_rx` with the acknowledge of data byte k lands in `rdata[8k+7:8k]`. Unused bytes of `rdata` are zero, and `rdata` is valid while `done` is high.
- R4: After any access that is not a soft reset, a three-byte frame 0x00, 0x14, 0x01 follows, and only then does `done` pulse.
- R5: A write to address 0x0000 with first data byte 0x81 gets no leave frame. After its `done` pulse, `req_ready` stays low and `busy` stays high for exactly `(CLK_HZ/1e6)*QUIET_US` cycles.
- R6: A request with `req_len` of 0 or greater than 6 (more than 8 bytes in the frame) is refused: `done` and `err` pulse together in the cycle after acceptance and no SPI byte is sent.
- R7: A write to address 0x0003–0x0006 or 0x000B–0x000D is refused the same way. Reads of those addresses, and writes to the neighbouring addresses, proceed normally.
- R8: A request is taken only while `req_ready` is high, which is the idle state. `req_valid` has no effect at any other time. A presented SPI byte and its `spi_last` stay unchanged until `spi_ack`.
- R9: No SPI frame ever holds more than `MAX_FRAME` (8) bytes.
- R10: `done` is a single-cycle pulse, and `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address |
| req_len | input | 3 | Number of data bytes (valid 1..6) |
| req_wdata | input | 48 | Write bytes, byte k in bits 8k+7:8k |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused (with done) |
| rdata | output | 48 | Read bytes, byte k in bits 8k+7:8k |
| busy | output | 1 | Access or quiet window in progress |
| spi_req | output | 1 | Byte presented to the shifter |
| spi_tx | output | 8 | Byte to send |
| spi_last | output | 1 | Presented byte ends its frame |
| spi_ack | input | 1 | Shifter has exchanged the presented byte |
| spi_rx | input | 8 | Byte received during the acknowledged exchange |

## Verification
Assertions check these behaviours on every cycle:
- The unlock byte directly follows each valid acceptance, and refusals pulse `done` with `err` in the next cycle.
- Presented bytes hold still until acknowledged, and no frame runs past eight bytes.
- The quiet counter steps down by one each cycle, and `done` never lasts two cycles.

Only the bench scenarios can show the following:
- The exact byte order of all three frames.
- The placement of returned read bytes.
- The absence of the leave frame after a soft reset, and the exact length of the lockout.
- That requests offered during the lockout are ignored.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
    localparam logic [7:0] ENTER_CMD = 8'hA0;
    localparam int         EXIT_REG  = 32'h14;
    localparam logic [7:0] EXIT_VAL  = 8'h01;
    localparam logic [7:0] RESET_VAL = 8'h81;
    localparam logic [7:0] RD_FLAG   = 8'h80;
    localparam int         RO_A_LO   = 3;
    localparam int         RO_A_HI   = 6;
    localparam int         RO_B_LO   = 11;
    localparam int         RO_B_HI   = 13;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REJECT,
        S_ENTER,
        S_XFER,
        S_EXIT,
        S_FINISH,
        S_QUIET
    } seq_state_t;
endpackage

// File: rtl/cfg_req_check.sv
module cfg_req_check import cfg_seq_pkg::*; #(
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 3,
    parameter int MAX_DATA = 6
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [7:0]        first_byte,
    output logic              bad_len,
    output logic              bad_ro,
    output logic              is_reset
);
    always_comb begin
        bad_len  = (len == '0) || (int'(len) > MAX_DATA);
        bad_ro   = wr && ((int'(addr) >= RO_A_LO && int'(addr) <= RO_A_HI) ||
                          (int'(addr) >= RO_B_LO && int'(addr) <= RO_B_HI));
        is_reset = wr && (addr == '0) && (first_byte == RESET_VAL);
    end
endmodule

// File: rtl/cfg_quiet_timer.sv
module cfg_quiet_timer #(
    parameter int CYCLES = 187500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (start)        cnt <= CNT_W'(CYCLES - 1);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R5: the lockout counts down one step per cycle until it expires
    a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !expired) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq import cfg_seq_pkg::*; #(
    parameter int CLK_HZ     = 250_000_000,
    parameter int QUIET_US   = 750,
    parameter int MAX_FRAME  = 8,
    parameter int ADDR_BYTES = 2
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        req_valid,
    output logic                                        req_ready,
    input  logic                                        req_write,
    input  logic [ADDR_BYTES*8-1:0]                     req_addr,
    input  logic [$clog2(MAX_FRAME-ADDR_BYTES+1)-1:0]   req_len,
    input  logic [(MAX_FRAME-ADDR_BYTES)*8-1:0]         req_wdata,
    output logic                                        done,
    output logic                                        err,
    output logic [(MAX_FRAME-ADDR_BYTES)*8-1:0]         rdata,
    output logic                                        busy,
    output logic                                        spi_req,
    output logic [7:0]                                  spi_tx,
    output logic                                        spi_last,
    input  logic                                        spi_ack,
    input  logic [7:0]                                  spi_rx
);
    localparam int MAX_DATA     = MAX_FRAME - ADDR_BYTES;
    localparam int ADDR_W       = ADDR_BYTES * 8;
    localparam int DATA_W       = MAX_DATA * 8;
    localparam int LEN_W        = $clog2(MAX_DATA + 1);
    localparam int POS_W        = $clog2(MAX_FRAME);
    localparam int QUIET_CYCLES = (CLK_HZ / 1_000_000) * QUIET_US;
    localparam logic [ADDR_W-1:0] EXIT_ADDR = ADDR_W'(EXIT_REG);

    seq_state_t         state, state_nx;
    logic               cur_wr, cur_reset;
    logic [ADDR_W-1:0]  cur_addr;
    logic [LEN_W-1:0]   cur_len;
    logic [DATA_W-1:0]  cur_wdata;
    logic [DATA_W-1:0]  rdata_q;
    logic [POS_W-1:0]   idx;
    logic               chk_bad_len, chk_bad_ro, chk_reset, reject_now;
    logic               accept, quiet_start, quiet_done;
    logic               xfer_last, exit_last;
    logic [7:0]         xfer_byte, exit_byte;

    cfg_req_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_DATA(MAX_DATA)) u_check (
        .wr(req_write), .addr(req_addr), .len(req_len), .first_byte(req_wdata[7:0]),
        .bad_len(chk_bad_len), .bad_ro(chk_bad_ro), .is_reset(chk_reset)
    );

    assign quiet_start = (state == S_FINISH) && cur_reset;

    cfg_quiet_timer #(.CYCLES(QUIET_CYCLES)) u_quiet (
        .clk(clk), .rst_n(rst_n), .start(quiet_start), .expired(quiet_done)
    );

    assign reject_now = chk_bad_len || chk_bad_ro;
    assign accept     = req_valid && (state == S_IDLE);
    assign xfer_last  = (int'(idx) == ADDR_BYTES + int'(cur_len) - 1);
    assign exit_last  = (int'(idx) == ADDR_BYTES);

    // byte selection for the addressed frame and the leave frame
    always_comb begin
        xfer_byte = '0;
        exit_byte = EXIT_VAL;
        if (int'(idx) < ADDR_BYTES) begin
            xfer_byte = cur_addr[(ADDR_BYTES - 1 - int'(idx)) * 8 +: 8];
            if (idx == '0 && !cur_wr) xfer_byte = xfer_byte | RD_FLAG;
            exit_byte = EXIT_ADDR[(ADDR_BYTES - 1 - int'(idx)) * 8 +: 8];
        end else if (cur_wr) begin
            xfer_byte = cur_wdata[(int'(idx) - ADDR_BYTES) * 8 +: 8];
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_valid) state_nx = reject_now ? S_REJECT : S_ENTER;
            S_REJECT: state_nx = S_IDLE;
            S_ENTER:  if (spi_ack) state_nx = S_XFER;
            S_XFER:   if (spi_ack && xfer_last) state_nx = cur_reset ? S_FINISH : S_EXIT;
            S_EXIT:   if (spi_ack && exit_last) state_nx = S_FINISH;
            S_FINISH: state_nx = cur_reset ? S_QUIET : S_IDLE;
            S_QUIET:  if (quiet_done) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        spi_req  = 1'b0;
        spi_tx   = '0;
        spi_last = 1'b0;
        done     = 1'b0;
        err      = 1'b0;
        unique case (state)
            S_ENTER:  begin spi_req = 1'b1; spi_tx = ENTER_CMD; spi_last = 1'b1; end
            S_XFER:   begin spi_req = 1'b1; spi_tx = xfer_byte; spi_last = xfer_last; end
            S_EXIT:   begin spi_req = 1'b1; spi_tx = exit_byte; spi_last = exit_last; end
            S_FINISH: done = 1'b1;
            S_REJECT: begin done = 1'b1; err = 1'b1; end
            default:  ;
        endcase
    end

    assign busy      = (state != S_IDLE);
    assign req_ready = (state == S_IDLE);
    assign rdata     = rdata_q;

    // request capture, byte position and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_wr    <= 1'b0;
            cur_reset <= 1'b0;
            cur_addr  <= '0;
            cur_len   <= '0;
            cur_wdata <= '0;
            rdata_q   <= '0;
            idx       <= '0;
        end else if (accept) begin
            cur_wr    <= req_write;
            cur_reset <= chk_reset;
            cur_addr  <= req_addr;
            cur_len   <= req_len;
            cur_wdata <= req_wdata;
            rdata_q   <= '0;
            idx       <= '0;
        end else if (spi_ack) begin
            if (state == S_XFER) begin
                if (!cur_wr && int'(idx) >= ADDR_BYTES)
                    rdata_q[(int'(idx) - ADDR_BYTES) * 8 +: 8] <= spi_rx;
                idx <= xfer_last ? '0 : idx + 1'b1;
            end else if (state == S_EXIT) begin
                idx <= exit_last ? '0 : idx + 1'b1;
            end
        end
    end

    // ---------------- assertions ----------------
    logic [POS_W:0] frame_pos;
    always_ff @(posedge clk) begin
        if (!rst_n)                  frame_pos <= '0;
        else if (spi_req && spi_ack) frame_pos <= spi_last ? '0 : frame_pos + 1'b1;
    end

    a_r1_enter_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !reject_now) |=> (spi_req && spi_tx == ENTER_CMD && spi_last));

    a_r6_r7_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && reject_now) |=> (done && err && !spi_req));

    a_r8_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx) && $stable(spi_last)));

    a_r9_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |-> (int'(frame_pos) < MAX_FRAME));

    a_r5_no_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_XFER && spi_ack && spi_last && cur_reset) |=> (done && !spi_req));

    a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/tb_cfg_access_seq.sv
module tb_cfg_access_seq;
    localparam int QN = 250;

    typedef struct {
        logic [7:0] b;
        logic       last;
        logic       rd;
        int         k;
        string      tag;
    } exp_byte_t;

    typedef struct {
        logic  err;
        logic  rd;
        string tag;
    } exp_res_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [2:0]  req_len = '0;
    logic [47:0] req_wdata = '0;
    logic        spi_ack = 1'b0;
    logic [7:0]  spi_rx = '0;
    logic        req_ready, done, err, busy, spi_req, spi_last;
    logic [47:0] rdata;
    logic [7:0]  spi_tx;

    int errors = 0;
    int checks = 0;
    exp_byte_t   spi_q[$];
    exp_res_t    res_q[$];
    logic [47:0] exp_rdata = '0;
    int          gap_cnt = 0;
    int          ack_num = 0;

    always #2 clk = ~clk;

    cfg_access_seq #(.CLK_HZ(250_000_000), .QUIET_US(1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .done(done), .err(err), .rdata(rdata), .busy(busy),
        .spi_req(spi_req), .spi_tx(spi_tx), .spi_last(spi_last),
        .spi_ack(spi_ack), .spi_rx(spi_rx)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // SPI shifter model and byte scoreboard
    always @(negedge clk) begin
        spi_ack = 1'b0;
        if (rst_n && spi_req) begin
            if (gap_cnt < (ack_num % 2)) begin
                gap_cnt++;
            end else begin
                logic [7:0] rx;
                gap_cnt = 0;
                rx = 8'h3C + 8'(ack_num * 7);
                if (spi_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected spi byte", {55'd0, spi_last, spi_tx}, 64'hFFFF);
                end else begin
                    exp_byte_t e;
                    e = spi_q.pop_front();
                    chk(spi_tx == e.b && spi_last == e.last, e.tag, "spi byte/last",
                        {55'd0, spi_last, spi_tx}, {55'd0, e.last, e.b});
                    if (e.rd) exp_rdata[e.k*8 +: 8] = rx;
                end
                spi_rx  = rx;
                spi_ack = 1'b1;
                ack_num++;
            end
        end
    end

    // completion scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (res_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected done", {63'd0, err}, 64'hFFFF);
            end else begin
                exp_res_t r;
                r = res_q.pop_front();
                chk(err == r.err, r.tag, "err flag", {63'd0, err}, {63'd0, r.err});
                if (r.rd && !r.err)
                    chk(rdata == exp_rdata, "R3", "read data", {16'd0, rdata}, {16'd0, exp_rdata});
            end
        end
    end

    task automatic send(input logic wr, input logic [15:0] addr, input logic [2:0] len,
                        input logic [47:0] wd, input logic exp_err, input logic is_rst,
                        input string tag);
        if (!exp_err) begin
            int n;
            n = int'(len);
            spi_q.push_back('{8'hA0, 1'b1, 1'b0, 0, "R1"});
            spi_q.push_back('{addr[15:8] | (wr ? 8'h00 : 8'h80), 1'b0, 1'b0, 0, "R2"});
            spi_q.push_back('{addr[7:0], 1'b0, 1'b0, 0, "R2"});
            for (int k = 0; k < n; k++)
                spi_q.push_back('{wr ? wd[k*8 +: 8] : 8'h00, (k == n - 1), !wr, k, wr ? "R2" : "R3"});
            if (!is_rst) begin
                spi_q.push_back('{8'h00, 1'b0, 1'b0, 0, "R4"});
                spi_q.push_back('{8'h14, 1'b0, 1'b0, 0, "R4"});
                spi_q.push_back('{8'h01, 1'b1, 1'b0, 0, "R4"});
            end
        end
        res_q.push_back('{exp_err, !wr, tag});
        exp_rdata = '0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = len; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (!is_rst)
            while (spi_q.size() != 0 || res_q.size() != 0 || !req_ready) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R8 watchdog expired act=hung exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cnt;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !busy && !spi_req && !done, "R8", "reset state",
            {60'd0, req_ready, busy, spi_req, done}, 64'b1000);

        send(1'b1, 16'h0020, 3'd1, 48'h5A, 1'b0, 1'b0, "R2");
        send(1'b1, 16'h1234, 3'd3, 48'hC3B2A1, 1'b0, 1'b0, "R2");
        send(1'b0, 16'h0011, 3'd2, 48'h0, 1'b0, 1'b0, "R3");
        send(1'b0, 16'h0102, 3'd6, 48'h0, 1'b0, 1'b0, "R3");
        send(1'b1, 16'h00FE, 3'd6, 48'h665544332211, 1'b0, 1'b0, "R9");
        // R7 read-only window: reads pass, writes refused, neighbours pass
        send(1'b0, 16'h0004, 3'd1, 48'h0, 1'b0, 1'b0, "R7");
        send(1'b1, 16'h0003, 3'd1, 48'h11, 1'b1, 1'b0, "R7");
        send(1'b1, 16'h0006, 3'd1, 48'h11, 1'b1, 1'b0, "R7");
        send(1'b1, 16'h000B, 3'd1, 48'h11, 1'b1, 1'b0, "R7");
        send(1'b1, 16'h000D, 3'd2, 48'h11, 1'b1, 1'b0, "R7");
        send(1'b1, 16'h0007, 3'd1, 48'h22, 1'b0, 1'b0, "R7");
        send(1'b1, 16'h000A, 3'd1, 48'h33, 1'b0, 1'b0, "R7");
        send(1'b1, 16'h000E, 3'd1, 48'h44, 1'b0, 1'b0, "R7");
        // R6 length limits
        send(1'b1, 16'h0020, 3'd0, 48'h0, 1'b1, 1'b0, "R6");
        send(1'b0, 16'h0020, 3'd7, 48'h0, 1'b1, 1'b0, "R6");
        // R5 near-misses of the reset pattern keep the leave frame
        send(1'b1, 16'h0000, 3'd1, 48'h80, 1'b0, 1'b0, "R5");
        send(1'b0, 16'h0000, 3'd1, 48'h81, 1'b0, 1'b0, "R5");
        send(1'b1, 16'h0100, 3'd1, 48'h81, 1'b0, 1'b0, "R5");

        // R5 soft reset: no leave frame, then exact lockout; R8 requests ignored meanwhile
        send(1'b1, 16'h0000, 3'd2, 48'h0781, 1'b0, 1'b1, "R5");
        while (!done) @(negedge clk);
        cnt = 0;
        forever begin
            @(negedge clk);
            if (req_ready || cnt > 1000) break;
            cnt++;
            chk(busy, "R5", "busy during lockout", {63'd0, busy}, 64'd1);
            if (cnt == 10) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0020;
                req_len = 3'd1; req_wdata = 48'h99;
            end
            if (cnt == 20) req_valid = 1'b0;
        end
        chk(cnt == QN, "R5", "lockout cycles", 64'(cnt), 64'(QN));
        repeat (3) @(negedge clk);
        chk(!busy && !spi_req, "R8", "request during lockout ignored",
            {62'd0, busy, spi_req}, 64'd0);

        send(1'b0, 16'h0021, 3'd1, 48'h0, 1'b0, 1'b0, "R3");
        repeat (4) @(negedge clk);
        chk(spi_q.size() == 0 && res_q.size() == 0, "R10", "all expected items seen",
            64'(spi_q.size() + res_q.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule